// File: doc/BRIEF.md
# Serial audio frame receiver

This block is the receive half of a buffered serial audio port. It watches a bit clock, a frame sync and a serial data line, all of which arrive from outside and are sampled in the system clock domain. Each frame sync marks the start of a frame. After a programmable number of bit clocks, the block shifts in a fixed number of words, most significant bit first. Each completed word is presented as a right-aligned parallel value, tagged with its position in the frame, and marked by a one-cycle ready pulse.

Configuration inputs select the word length through a coded field, the number of words per frame, the delay from frame sync to the first data bit, the bit clock edge used for sampling, and the active level of frame sync. The receiver has its own reset-release input. A change on that input only takes effect at a transition of the bit clock, and the current state is reported on a status output. A consumer acknowledges each word. If a word completes while the previous one is still unacknowledged, a sticky overrun flag is raised.

Top module: `srx_frame_rx`

## Requirements
- R1: `cfg_wlen_code` sets the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. The first received bit is the word's most significant bit. The word is presented right-aligned in `rx_word`, with all bits above the word length at zero.
- R2: A frame holds `cfg_frame_len`+1 words, delivered back to back with `rx_slot` counting 0, 1, and so on. After the last word, data bits are ignored until the next frame sync.
- R3: A frame begins on the sampling edge where frame sync is first seen active. With `cfg_delay`=0 that same edge carries the first data bit. With `cfg_delay`=N the first data bit is taken N sampling edges later.
- R4: With `cfg_clk_pol`=1 the line is sampled on rising bit clock edges. With 0 it is sampled on falling edges.
- R5: With `cfg_fs_pol`=0 the frame sync is active high. With 1 it is active low.
- R6: While `rx_out_of_reset` is 0, no word is delivered. A change of `cfg_enable` reaches `rx_out_of_reset` only after a bit clock transition, and not while the bit clock is steady.
- R7: `rx_ready` is a single-cycle pulse for each completed word. `rx_word` and `rx_slot` are valid while it is high.
- R8: `rx_overrun` is set when a word completes while the previous word is unacknowledged. An `rd_ack` that is high in the completion cycle counts as acknowledged in time. The flag stays set until the receiver is put back in reset.
- R9: A frame sync that arrives in the middle of a word or frame discards the partial word and restarts the frame at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_dat | input | 1 | Serial data line |
| cfg_enable | input | 1 | Receiver reset release (1 = run) |
| cfg_wlen_code | input | 3 | Word length code |
| cfg_frame_len | input | FLEN_W | Words per frame minus one |
| cfg_delay | input | DELAY_W | Sampling edges from frame sync to first data bit |
| cfg_clk_pol | input | 1 | Sampling edge select (1 = rising) |
| cfg_fs_pol | input | 1 | Frame sync level (1 = active low) |
| rd_ack | input | 1 | Acknowledge of the presented word |
| rx_word | output | WORD_W | Received word, right-aligned |
| rx_slot | output | FLEN_W | Word position in its frame |
| rx_ready | output | 1 | Word-complete pulse |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_out_of_reset | output | 1 | Receiver running status |

## Verification
Word completion and the consumer's acknowledge can fall in the same system clock cycle, and the overrun decision depends on how they are ordered. The bench provokes this by holding `rd_ack` high through a four-word frame, so that every completion coincides with an acknowledge. It expects all words to arrive with `rx_overrun` still low. It then withholds the acknowledge over a two-word frame and expects the flag to rise and stay set until the receiver is reset.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int SRX_CODE_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DELAY,
      ST_DATA
   } srx_state_e;

   // Bit count selected by the word length code; codes above 5 act as 32.
   function automatic logic [5:0] srx_code_bits(input logic [SRX_CODE_W-1:0] code);
      case (code)
         3'd0:    srx_code_bits = 6'd8;
         3'd1:    srx_code_bits = 6'd12;
         3'd2:    srx_code_bits = 6'd16;
         3'd3:    srx_code_bits = 6'd20;
         3'd4:    srx_code_bits = 6'd24;
         default: srx_code_bits = 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/srx_pin_stage.sv
module srx_pin_stage #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic fs_i,
   input  logic dat_i,
   input  logic clk_pol,
   input  logic fs_pol,
   output logic smp_o,
   output logic edge_o,
   output logic fs_act_o,
   output logic dat_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] bclk_s, fs_s, dat_s;
   logic              bclk_d;
   logic              rise, fall;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bclk_s <= '0;
               fs_s   <= '0;
               dat_s  <= '0;
            end else begin
               bclk_s[0] <= bclk_i;
               fs_s[0]   <= fs_i;
               dat_s[0]  <= dat_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bclk_s <= '0;
               fs_s   <= '0;
               dat_s  <= '0;
            end else begin
               bclk_s <= {bclk_s[STAGES-2:0], bclk_i};
               fs_s   <= {fs_s[STAGES-2:0], fs_i};
               dat_s  <= {dat_s[STAGES-2:0], dat_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s[LAST];
   end

   always_comb begin
      rise     = bclk_s[LAST] & ~bclk_d;
      fall     = ~bclk_s[LAST] & bclk_d;
      smp_o    = clk_pol ? rise : fall;
      edge_o   = rise | fall;
      fs_act_o = fs_s[LAST] ^ fs_pol;
      dat_o    = dat_s[LAST];
   end

endmodule

// File: rtl/srx_reset_gate.sv
module srx_reset_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_edge,
   input  logic enable,
   output logic active
);
   // The receiver follows its release bit only when the bit clock moves.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         active <= 1'b0;
      else if (bclk_edge) active <= enable;
   end

endmodule

// File: rtl/srx_deser.sv
module srx_deser
   import srx_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int FLEN_W  = 7,
   parameter int DELAY_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               smp,
   input  logic               fs_act,
   input  logic               dat,
   input  logic [SRX_CODE_W-1:0] wlen_code,
   input  logic [FLEN_W-1:0]  frame_len,
   input  logic [DELAY_W-1:0] delay,
   output logic               word_done,
   output logic [WORD_W-1:0]  word,
   output logic [FLEN_W-1:0]  slot
);
   localparam int CNT_W = $clog2(WORD_W + 1);

   srx_state_e         state_q;
   logic               fs_prev_q;
   logic [DELAY_W-1:0] dly_q;
   logic [CNT_W-1:0]   cnt_q, cnt_nx, wl;
   logic [WORD_W-1:0]  sh_q, sh_keep, sh_nx;
   logic [FLEN_W-1:0]  slot_q;
   logic               fs_start, take_bit;

   always_comb begin
      wl       = CNT_W'(srx_code_bits(wlen_code));
      fs_start = active && smp && fs_act && !fs_prev_q;
      take_bit = 1'b0;
      if (active && smp) begin
         if (fs_start)                take_bit = (delay == '0);
         else if (state_q == ST_DATA)  take_bit = 1'b1;
         else if (state_q == ST_DELAY) take_bit = (dly_q == DELAY_W'(1));
      end
      cnt_nx    = (fs_start ? '0 : cnt_q) + CNT_W'(1);
      sh_keep   = fs_start ? '0 : sh_q;
      sh_nx     = {sh_keep[WORD_W-2:0], dat};
      word_done = take_bit && (cnt_nx == wl);
      word      = sh_nx;
      slot      = fs_start ? '0 : slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         fs_prev_q <= 1'b0;
         dly_q     <= '0;
         cnt_q     <= '0;
         sh_q      <= '0;
         slot_q    <= '0;
      end else if (!active) begin
         state_q   <= ST_IDLE;
         fs_prev_q <= 1'b0;
         dly_q     <= '0;
         cnt_q     <= '0;
         sh_q      <= '0;
         slot_q    <= '0;
      end else if (smp) begin
         fs_prev_q <= fs_act;
         if (fs_start) begin
            // Restart the frame, dropping any partial word.
            slot_q <= '0;
            cnt_q  <= '0;
            sh_q   <= '0;
            dly_q  <= delay;
            state_q <= (delay == '0) ? ST_DATA : ST_DELAY;
         end else if (state_q == ST_DELAY && !take_bit) begin
            dly_q <= dly_q - DELAY_W'(1);
         end
         if (take_bit) begin
            if (word_done) begin
               cnt_q <= '0;
               sh_q  <= '0;
               if (slot == frame_len) begin
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_DATA;
                  slot_q  <= slot + FLEN_W'(1);
               end
            end else begin
               cnt_q   <= cnt_nx;
               sh_q    <= sh_nx;
               state_q <= ST_DATA;
            end
         end
      end
   end

endmodule

// File: rtl/srx_frame_rx.sv
module srx_frame_rx
   import srx_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int FLEN_W      = 7,
   parameter int DELAY_W     = 2,
   parameter int SYNC_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_bclk,
   input  logic               rx_fs,
   input  logic               rx_dat,
   input  logic               cfg_enable,
   input  logic [2:0]         cfg_wlen_code,
   input  logic [FLEN_W-1:0]  cfg_frame_len,
   input  logic [DELAY_W-1:0] cfg_delay,
   input  logic               cfg_clk_pol,
   input  logic               cfg_fs_pol,
   input  logic               rd_ack,
   output logic [WORD_W-1:0]  rx_word,
   output logic [FLEN_W-1:0]  rx_slot,
   output logic               rx_ready,
   output logic               rx_overrun,
   output logic               rx_out_of_reset
);
   generate
      if (WORD_W < 32) begin : g_bad_word_w
         $error("srx_frame_rx: WORD_W must hold a 32-bit word");
      end
      if (FLEN_W < 1) begin : g_bad_flen_w
         $error("srx_frame_rx: FLEN_W must be at least 1");
      end
      if (DELAY_W < 1) begin : g_bad_delay_w
         $error("srx_frame_rx: DELAY_W must be at least 1");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_stages
         $error("srx_frame_rx: SYNC_STAGES must be 1 or 2");
      end
   endgenerate

   logic              smp, bclk_edge, fs_act, dat_s, active;
   logic              done_c, pend_q;
   logic [WORD_W-1:0] word_c;
   logic [FLEN_W-1:0] slot_c;

   srx_pin_stage #(.STAGES(SYNC_STAGES)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (rx_bclk),
      .fs_i     (rx_fs),
      .dat_i    (rx_dat),
      .clk_pol  (cfg_clk_pol),
      .fs_pol   (cfg_fs_pol),
      .smp_o    (smp),
      .edge_o   (bclk_edge),
      .fs_act_o (fs_act),
      .dat_o    (dat_s)
   );

   srx_reset_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_edge (bclk_edge),
      .enable    (cfg_enable),
      .active    (active)
   );

   srx_deser #(.WORD_W(WORD_W), .FLEN_W(FLEN_W), .DELAY_W(DELAY_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .smp       (smp),
      .fs_act    (fs_act),
      .dat       (dat_s),
      .wlen_code (cfg_wlen_code),
      .frame_len (cfg_frame_len),
      .delay     (cfg_delay),
      .word_done (done_c),
      .word      (word_c),
      .slot      (slot_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word  <= '0;
         rx_slot  <= '0;
         rx_ready <= 1'b0;
      end else begin
         rx_ready <= done_c;
         if (done_c) begin
            rx_word <= word_c;
            rx_slot <= slot_c;
         end
      end
   end

   // The acknowledge refers to the word presented before this cycle's edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         rx_overrun <= 1'b0;
      end else if (!active) begin
         pend_q     <= 1'b0;
         rx_overrun <= 1'b0;
      end else if (done_c) begin
         if (pend_q && !rd_ack) rx_overrun <= 1'b1;
         pend_q <= 1'b1;
      end else if (rd_ack) begin
         pend_q <= 1'b0;
      end
   end

   assign rx_out_of_reset = active;

endmodule

// File: rtl/srx_frame_rx_chk.sv
module srx_frame_rx_chk
   import srx_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int FLEN_W = 7,
   parameter int STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_bclk,
   input logic [2:0]        cfg_wlen_code,
   input logic [FLEN_W-1:0] cfg_frame_len,
   input logic [WORD_W-1:0] rx_word,
   input logic [FLEN_W-1:0] rx_slot,
   input logic              rx_ready,
   input logic              rx_overrun,
   input logic              rx_out_of_reset
);
   logic [WORD_W-1:0] wmask;
   always_comb wmask = {WORD_W{1'b1}} >> (WORD_W - int'(srx_code_bits(cfg_wlen_code)));

   AST_WORD_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> ((rx_word & ~wmask) == '0)); // R1

   AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (rx_slot <= cfg_frame_len)); // R2

   AST_NO_WORD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_out_of_reset && !$past(rx_out_of_reset)) |-> !rx_ready); // R6

   AST_RELEASE_NEEDS_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_out_of_reset) |-> ($past(rx_bclk, STAGES + 1) != $past(rx_bclk, STAGES + 2))); // R6

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |=> !rx_ready); // R7

   AST_OVERRUN_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> rx_ready); // R8

   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> (rx_overrun || !rx_out_of_reset)); // R8

endmodule

bind srx_frame_rx srx_frame_rx_chk #(
   .WORD_W (WORD_W),
   .FLEN_W (FLEN_W),
   .STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_srx_frame_rx.sv
module tb_srx_frame_rx;
   localparam int WORD_W  = 32;
   localparam int FLEN_W  = 7;
   localparam int DELAY_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bclk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;
   logic cfg_enable = 1'b0;
   logic [2:0] cfg_wlen_code = 3'd2;
   logic [FLEN_W-1:0] cfg_frame_len = 7'd1;
   logic [DELAY_W-1:0] cfg_delay = 2'd1;
   logic clk_pol_b = 1'b1, fs_pol_b = 1'b0;
   logic rd_ack = 1'b0;
   logic [WORD_W-1:0] rx_word;
   logic [FLEN_W-1:0] rx_slot;
   logic rx_ready, rx_overrun, rx_out_of_reset;

   int checks = 0, failures = 0;
   int ack_mode = 1;            // 0 never, 1 pulse after ready, 2 held high
   logic prev_ready = 1'b0;
   logic [31:0] fw [4];

   logic [31:0] q_word [$];
   int          q_slot [$];
   string       q_req  [$];

   always #4 clk = ~clk;

   srx_frame_rx #(.WORD_W(WORD_W), .FLEN_W(FLEN_W), .DELAY_W(DELAY_W)) dut (
      .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_dat(rx_dat),
      .cfg_enable(cfg_enable), .cfg_wlen_code(cfg_wlen_code), .cfg_frame_len(cfg_frame_len),
      .cfg_delay(cfg_delay), .cfg_clk_pol(clk_pol_b), .cfg_fs_pol(fs_pol_b), .rd_ack(rd_ack),
      .rx_word(rx_word), .rx_slot(rx_slot), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
      .rx_out_of_reset(rx_out_of_reset)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int code_len(input logic [2:0] c);
      int t [6] = '{8, 12, 16, 20, 24, 32};
      return (c > 3'd5) ? 32 : t[c];
   endfunction

   // One bit clock period; the sampling edge falls in the middle.
   task automatic bit_period(input logic fs_on, input logic d);
      rx_dat  = d;
      rx_fs   = fs_on ^ fs_pol_b;
      rx_bclk = ~clk_pol_b;
      repeat (4) @(negedge clk);
      rx_bclk = clk_pol_b;
      repeat (4) @(negedge clk);
   endtask

   task automatic idle(input int n, input logic d);
      for (int i = 0; i < n; i++) bit_period(1'b0, d);
   endtask

   // Driver: queue the expected words, then put the frame on the line.
   task automatic send_frame(input int nwords, input string req);
      int wl = code_len(cfg_wlen_code);
      int dl = int'(cfg_delay);
      logic [31:0] m = 32'hFFFF_FFFF >> (32 - wl);
      for (int w = 0; w < nwords; w++) begin
         q_word.push_back(fw[w] & m);
         q_slot.push_back(w);
         q_req.push_back(req);
      end
      for (int p = 0; p < dl; p++) bit_period(p == 0, 1'b1);
      for (int w = 0; w < nwords; w++)
         for (int b = wl - 1; b >= 0; b--)
            bit_period(dl == 0 && w == 0 && b == wl - 1, fw[w][b]);
   endtask

   // Monitor: pop and compare on every ready pulse; drive the acknowledge.
   always @(negedge clk) begin
      rd_ack <= (ack_mode == 2) || (ack_mode == 1 && rx_ready);
      if (rst_n && rx_ready) begin
         if (prev_ready) chk("R7", "ready wider than one cycle", 64'd1, 64'd0);
         if (q_word.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R2/R6/R9 unexpected word actual=%0h expected=none", rx_word);
         end else begin
            string r = q_req.pop_front();
            chk(r, "word", 64'(rx_word), 64'(q_word.pop_front()));
            chk(r, "slot", 64'(rx_slot), 64'(q_slot.pop_front()));
         end
      end
      prev_ready <= rx_ready;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R6: reset state
      chk("R6", "status after reset", 64'(rx_out_of_reset), 64'd0);
      chk("R7", "ready after reset", 64'(rx_ready), 64'd0);
      chk("R8", "overrun after reset", 64'(rx_overrun), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R6: a frame while held in reset produces nothing
      fw[0] = 32'h1111; fw[1] = 32'h2222;
      for (int p = 0; p < 33; p++) bit_period(p == 0, p[0]);
      chk("R6", "status while disabled", 64'(rx_out_of_reset), 64'd0);

      // R6: release needs a bit clock transition
      cfg_enable = 1'b1;
      repeat (10) @(negedge clk);
      chk("R6", "release with steady bclk", 64'(rx_out_of_reset), 64'd0);
      idle(2, 1'b0);
      chk("R6", "release after bclk toggle", 64'(rx_out_of_reset), 64'd1);

      // R1 R3 R7: 16-bit, delay 1, two words
      fw[0] = 32'hA5C3; fw[1] = 32'h1234;
      send_frame(2, "R1_R3");
      idle(2, 1'b0);

      // R1 R3: 8-bit, delay 0
      cfg_wlen_code = 3'd0; cfg_delay = 2'd0;
      fw[0] = 32'hFFA7; fw[1] = 32'h5E;
      send_frame(2, "R1_R3");
      idle(1, 1'b0);

      // R1 R3: 12-bit, delay 2
      cfg_wlen_code = 3'd1; cfg_delay = 2'd2;
      fw[0] = 32'hABC; fw[1] = 32'h123;
      send_frame(2, "R1_R3");
      idle(1, 1'b0);

      // R1: 20-bit and 24-bit
      cfg_wlen_code = 3'd3; cfg_delay = 2'd1;
      fw[0] = 32'hF_00FF; fw[1] = 32'h8_0001;
      send_frame(2, "R1");
      idle(1, 1'b0);
      cfg_wlen_code = 3'd4;
      fw[0] = 32'hC3_5A69; fw[1] = 32'h80_0000;
      send_frame(2, "R1");
      idle(1, 1'b0);

      // R1 R2: 32-bit, four words per frame
      cfg_wlen_code = 3'd5; cfg_frame_len = 7'd3;
      fw[0] = 32'hDEAD_BEEF; fw[1] = 32'h0000_0001; fw[2] = 32'h8000_0000; fw[3] = 32'h1357_9BDF;
      send_frame(4, "R1_R2");
      idle(2, 1'b0);

      // R4: falling-edge sampling
      cfg_wlen_code = 3'd2; cfg_frame_len = 7'd1; clk_pol_b = 1'b0;
      idle(2, 1'b0);
      fw[0] = 32'h6C39; fw[1] = 32'h93C6;
      send_frame(2, "R4");
      idle(2, 1'b0);
      clk_pol_b = 1'b1;

      // R5: active-low frame sync
      fs_pol_b = 1'b1;
      idle(2, 1'b0);
      fw[0] = 32'h0F0F; fw[1] = 32'hF0F0;
      send_frame(2, "R5");
      idle(2, 1'b0);
      fs_pol_b = 1'b0;
      idle(2, 1'b0);

      // R2: one-word frame, trailing bits ignored
      cfg_frame_len = 7'd0; cfg_wlen_code = 3'd0; cfg_delay = 2'd0;
      fw[0] = 32'h3C;
      send_frame(1, "R2");
      idle(12, 1'b1);
      chk("R2", "words left after trailing bits", 64'(q_word.size()), 64'd0);

      // R9: frame sync inside a word restarts the frame
      cfg_frame_len = 7'd1; cfg_wlen_code = 3'd2; cfg_delay = 2'd1;
      idle(1, 1'b0);
      bit_period(1'b1, 1'b1);
      for (int i = 0; i < 5; i++) bit_period(1'b0, 1'b1);
      fw[0] = 32'h0246; fw[1] = 32'h8ACE;
      send_frame(2, "R9");
      idle(2, 1'b0);

      // R8: acknowledge held high; every completion meets an acknowledge
      ack_mode = 2;
      cfg_frame_len = 7'd3; cfg_wlen_code = 3'd0;
      fw[0] = 32'h11; fw[1] = 32'h22; fw[2] = 32'h33; fw[3] = 32'h44;
      send_frame(4, "R8");
      idle(2, 1'b0);
      chk("R8", "overrun with same-cycle ack", 64'(rx_overrun), 64'd0);

      // R8: no acknowledge, second word overruns
      ack_mode = 0;
      @(negedge clk);
      cfg_frame_len = 7'd1;
      fw[0] = 32'hA1; fw[1] = 32'hB2;
      send_frame(2, "R8");
      idle(2, 1'b0);
      chk("R8", "overrun without ack", 64'(rx_overrun), 64'd1);
      ack_mode = 1;
      fw[0] = 32'hC3; fw[1] = 32'hD4;
      send_frame(2, "R8");
      idle(2, 1'b0);
      chk("R8", "overrun sticky", 64'(rx_overrun), 64'd1);

      // R6 R8: hold in reset again
      cfg_enable = 1'b0;
      repeat (10) @(negedge clk);
      chk("R6", "status held with steady bclk", 64'(rx_out_of_reset), 64'd1);
      idle(1, 1'b0);
      chk("R6", "status after disable toggle", 64'(rx_out_of_reset), 64'd0);
      chk("R8", "overrun cleared by receiver reset", 64'(rx_overrun), 64'd0);
      for (int p = 0; p < 20; p++) bit_period(p == 0, 1'b1);

      repeat (4) @(negedge clk);
      chk("R7", "expected words outstanding", 64'(q_word.size()), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule